// File: doc/BRIEF.md
# Character Line Height Expander

This block sits in the vertical path of a character overlay generator. It turns the sequence of scan lines that make up one text row into a sequence of font line indices for an 18-line glyph. A 7-bit height code sets how many times each glyph line appears. The low five bits ask for extra lines with weights 16, 8, 4, 2 and 1, and the request is capped at 17. The two high bits can repeat the whole glyph once or twice more. A row therefore spans between 18 and 71 glyph lines. A per-row double-height bit doubles every line, and a 5-bit spacing value appends blank lines below the text.

Each text row begins with a row-start pulse. Each scan line is consumed by a line strobe. The block presents the current font line index and a blank-line flag, and raises an end-of-row pulse on the strobe that consumes the last line of the row. All three settings are captured at row start, so register writes made during a row only affect the next row. Extra lines from the binary request are spread evenly over the glyph by a remainder accumulator, so that no glyph line gains more than one copy from that term.

Top module: `osd_line_expander`

## Requirements
- R1: While glyph lines are shown, `fontLine` stays within 0..17, rises in steps of one, and each glyph line occupies consecutive scan lines.
- R2: The number of inserted lines is the binary value of `heightCode[4:0]` (bit weights 16, 8, 4, 2, 1), limited to 17. Example: code 0x0D gives 31 lines and code 0x19 gives 35.
- R3: With n inserted lines, glyph line g gets one extra copy exactly when floor((g+1)*n/18) is greater than floor(g*n/18).
- R4: `heightCode[6:5]` = 2'b11 adds two copies of every glyph line, 2'b10 adds one copy, and 2'b0x adds none. Example: code 0x4A gives 46 lines, code 0x7F gives 71, and code 0 gives 18.
- R5: When `dblHeight` is 1, every copy count from R2 to R4 is doubled.
- R6: After the glyph lines, `rowSpace` blank lines follow, with `blankLine`=1 and `fontLine`=0.
- R7: `rowEnd` is high, in the same cycle, only while a `lineStb` consumes the last line of the row. That is the last spacing line, or the last glyph line when `rowSpace` is 0. Afterwards the block is idle.
- R8: `heightCode`, `dblHeight` and `rowSpace` are sampled only on `rowStart`. Changing them during a row has no effect on that row.
- R9: `rowStart` restarts the row at glyph line 0 even in the middle of a row. When it arrives together with `lineStb`, the strobe is not consumed and no `rowEnd` is given.
- R10: After reset, and after a row ends, the block is idle: `blankLine`=1, `fontLine`=0, `rowEnd`=0. A `lineStb` in this state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| heightCode | input | 7 | Height code: [4:0] insertion request, [6:5] whole-glyph repeat |
| dblHeight | input | 1 | Double height for the row |
| rowSpace | input | 5 | Blank lines appended after the row |
| lineStb | input | 1 | Consume the current scan line |
| rowStart | input | 1 | Begin a new text row |
| fontLine | output | 5 | Font line index 0..17 |
| blankLine | output | 1 | Current line is blank (spacing or idle) |
| rowEnd | output | 1 | Current strobe consumes the last line of the row |

## Verification
Two functions can fall in the same cycle: a new row can begin while a line strobe is consuming a line, and a strobe can hit a glyph-line boundary while the insertion remainder carries over. The bench drives `rowStart` and `lineStb` together in the middle of a row, and also in the cycle that would otherwise end the row. The behavioural model in the bench expects a restart at glyph line 0, with no consumed line and no `rowEnd`. The outputs are compared with a queue of expected lines on every clock, so any error in line order, copy count or end pulse is caught at the cycle where it happens.

// File: rtl/osd_lx_pkg.sv
package osd_lx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GLYPH = 2'd1,
    PH_SPACE = 2'd2
  } lxPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture settings, restart at glyph line 0
    logic stepCopy;   // next copy of the same glyph line
    logic nextGlyph;  // move to the following glyph line
    logic stepSpace;  // next blank spacing line
  } lxStrobes_t;

endpackage

// File: rtl/lx_datapath.sv
module lx_datapath
  import osd_lx_pkg::*;
#(
  parameter int GLYPH_LINES = 18,
  parameter int INS_CAP     = 17,
  parameter int CODE_W      = 7,
  parameter int SPACE_W     = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [CODE_W-1:0]               heightCode,
  input  logic                            dblHeight,
  input  logic [SPACE_W-1:0]              rowSpace,
  input  lxStrobes_t                      strobes,
  output logic [$clog2(GLYPH_LINES)-1:0]  glyphIdx,
  output logic                            lastCopy,
  output logic                            lastGlyph,
  output logic                            lastSpace,
  output logic                            noSpace
);

  localparam int INS_W = CODE_W - 2;
  localparam int REM_W = $clog2(GLYPH_LINES);
  localparam int SUM_W = REM_W + 1;
  localparam int CNT_W = 4;  // up to (1+2+1)*2 = 8 copies

  // settings captured at row start
  logic [REM_W-1:0]   insN;
  logic [1:0]         repN;
  logic               dblR;
  logic [SPACE_W-1:0] spaceR;

  // running state
  logic [REM_W-1:0]   rem;
  logic [CNT_W-1:0]   copyCnt;
  logic [SPACE_W-1:0] spaceCnt;

  // decode of the height code
  logic [INS_W-1:0] insReq;
  logic [REM_W-1:0] insCapped;
  logic [1:0]       repSel;

  always_comb begin
    insReq = heightCode[INS_W-1:0];
    if (int'(insReq) > INS_CAP) insCapped = REM_W'(INS_CAP);
    else                        insCapped = REM_W'(insReq);
    if (heightCode[CODE_W-1]) repSel = heightCode[CODE_W-2] ? 2'd2 : 2'd1;
    else                      repSel = 2'd0;
  end

  // insertion spreading: remainder carries past the glyph height
  logic [SUM_W-1:0] remSum;
  logic             curIns;
  logic [REM_W-1:0] remNext;
  logic [CNT_W-1:0] copiesNeeded;

  always_comb begin
    remSum  = SUM_W'(rem) + SUM_W'(insN);
    curIns  = remSum >= SUM_W'(GLYPH_LINES);
    remNext = curIns ? REM_W'(remSum - SUM_W'(GLYPH_LINES)) : REM_W'(remSum);
    copiesNeeded = CNT_W'((CNT_W'(repN) + CNT_W'(curIns) + CNT_W'(1)) << dblR);
  end

  assign lastCopy  = (copyCnt == copiesNeeded - CNT_W'(1));
  assign lastGlyph = (glyphIdx == REM_W'(GLYPH_LINES - 1));
  assign noSpace   = (spaceR == '0);
  assign lastSpace = (spaceCnt == spaceR - SPACE_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insN     <= '0;
      repN     <= '0;
      dblR     <= 1'b0;
      spaceR   <= '0;
      rem      <= '0;
      copyCnt  <= '0;
      spaceCnt <= '0;
      glyphIdx <= '0;
    end else if (strobes.load) begin
      insN     <= insCapped;
      repN     <= repSel;
      dblR     <= dblHeight;
      spaceR   <= rowSpace;
      rem      <= '0;
      copyCnt  <= '0;
      spaceCnt <= '0;
      glyphIdx <= '0;
    end else begin
      if (strobes.stepCopy) copyCnt <= copyCnt + CNT_W'(1);
      if (strobes.nextGlyph) begin
        copyCnt  <= '0;
        glyphIdx <= glyphIdx + REM_W'(1);
        rem      <= remNext;
      end
      if (strobes.stepSpace) spaceCnt <= spaceCnt + SPACE_W'(1);
    end
  end

  AST_GLYPH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(glyphIdx) < GLYPH_LINES); // R1
  AST_GLYPH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nextGlyph && !strobes.load |=> glyphIdx == $past(glyphIdx) + REM_W'(1)); // R1
  AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(rem) < GLYPH_LINES); // R3
  AST_INS_CAP: assert property (@(posedge clk) disable iff (!rstN)
    int'(insN) <= INS_CAP); // R2
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(insN) && $stable(repN) && $stable(dblR) && $stable(spaceR)); // R8

endmodule

// File: rtl/lx_ctrl.sv
module lx_ctrl
  import osd_lx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowStart,
  input  logic       lineStb,
  input  logic       lastCopy,
  input  logic       lastGlyph,
  input  logic       lastSpace,
  input  logic       noSpace,
  output lxStrobes_t strobes,
  output lxPhase_t   phase,
  output logic       rowEnd
);

  lxPhase_t phaseNext;

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    rowEnd    = 1'b0;
    if (rowStart) begin
      strobes.load = 1'b1;
      phaseNext    = PH_GLYPH;
    end else if (lineStb) begin
      unique case (phase)
        PH_GLYPH: begin
          if (lastCopy && lastGlyph) begin
            if (noSpace) begin
              phaseNext = PH_IDLE;
              rowEnd    = 1'b1;
            end else begin
              phaseNext = PH_SPACE;
            end
          end else if (lastCopy) begin
            strobes.nextGlyph = 1'b1;
          end else begin
            strobes.stepCopy = 1'b1;
          end
        end
        PH_SPACE: begin
          if (lastSpace) begin
            phaseNext = PH_IDLE;
            rowEnd    = 1'b1;
          end else begin
            strobes.stepSpace = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.stepCopy, strobes.nextGlyph, strobes.stepSpace})); // R1
  AST_ROWEND_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rowEnd |=> phase == PH_IDLE); // R7
  AST_ROWEND_NEEDS_STB: assert property (@(posedge clk) disable iff (!rstN)
    rowEnd |-> lineStb && !rowStart); // R9
  AST_LOAD_GLYPH: assert property (@(posedge clk) disable iff (!rstN)
    rowStart |=> phase == PH_GLYPH); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_IDLE && !rowStart |=> phase == PH_IDLE); // R10

endmodule

// File: rtl/osd_line_expander.sv
module osd_line_expander
  import osd_lx_pkg::*;
#(
  parameter int GLYPH_LINES = 18,
  parameter int INS_CAP     = 17,
  parameter int CODE_W      = 7,
  parameter int SPACE_W     = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [CODE_W-1:0]              heightCode,
  input  logic                           dblHeight,
  input  logic [SPACE_W-1:0]             rowSpace,
  input  logic                           lineStb,
  input  logic                           rowStart,
  output logic [$clog2(GLYPH_LINES)-1:0] fontLine,
  output logic                           blankLine,
  output logic                           rowEnd
);

  localparam int LINE_W = $clog2(GLYPH_LINES);

  lxStrobes_t        strobes;
  lxPhase_t          phase;
  logic [LINE_W-1:0] glyphIdx;
  logic              lastCopy, lastGlyph, lastSpace, noSpace;

  lx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rowStart  (rowStart),
    .lineStb   (lineStb),
    .lastCopy  (lastCopy),
    .lastGlyph (lastGlyph),
    .lastSpace (lastSpace),
    .noSpace   (noSpace),
    .strobes   (strobes),
    .phase     (phase),
    .rowEnd    (rowEnd)
  );

  lx_datapath #(
    .GLYPH_LINES (GLYPH_LINES),
    .INS_CAP     (INS_CAP),
    .CODE_W      (CODE_W),
    .SPACE_W     (SPACE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .heightCode (heightCode),
    .dblHeight  (dblHeight),
    .rowSpace   (rowSpace),
    .strobes    (strobes),
    .glyphIdx   (glyphIdx),
    .lastCopy   (lastCopy),
    .lastGlyph  (lastGlyph),
    .lastSpace  (lastSpace),
    .noSpace    (noSpace)
  );

  assign blankLine = (phase != PH_GLYPH);
  assign fontLine  = blankLine ? '0 : glyphIdx;

endmodule

// File: tb/sim_osd_line_expander.sv
module sim_osd_line_expander;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] heightCode = '0;
  logic       dblHeight = 1'b0;
  logic [4:0] rowSpace = '0;
  logic       lineStb = 1'b0;
  logic       rowStart = 1'b0;
  logic [4:0] fontLine;
  logic       blankLine;
  logic       rowEnd;

  int checks = 0;
  int fails  = 0;
  int q[$];          // expected lines: glyph index, or -1 for blank
  bit sawEnd;

  always #10 clk = ~clk;

  osd_line_expander u0 (
    .clk(clk), .rstN(rstN), .heightCode(heightCode), .dblHeight(dblHeight),
    .rowSpace(rowSpace), .lineStb(lineStb), .rowStart(rowStart),
    .fontLine(fontLine), .blankLine(blankLine), .rowEnd(rowEnd)
  );

  task automatic buildRow(input logic [6:0] code, input logic dbl, input logic [4:0] sp);
    int n, rep, k;
    q.delete();
    n = int'(code[4:0]);
    if (n > 17) n = 17;                                  // R2
    rep = code[6] ? (code[5] ? 2 : 1) : 0;               // R4
    for (int g = 0; g < 18; g++) begin
      k = 1 + rep + (((g + 1) * n) / 18 - (g * n) / 18); // R3
      if (dbl) k = k * 2;                                // R5
      for (int c = 0; c < k; c++) q.push_back(g);
    end
    for (int s = 0; s < int'(sp); s++) q.push_back(-1);  // R6
  endtask

  // one clock: drive, compare at negedge, advance model
  task automatic step(input logic rs, input logic ls);
    int  expFont;
    logic expBlank, expEnd;
    rowStart = rs;
    lineStb  = ls;
    @(negedge clk);
    if (q.size() == 0) begin expFont = 0; expBlank = 1'b1; end
    else if (q[0] < 0) begin expFont = 0; expBlank = 1'b1; end
    else begin expFont = q[0]; expBlank = 1'b0; end
    expEnd = ls && !rs && q.size() == 1;
    checks++;
    if (int'(fontLine) != expFont || blankLine != expBlank || rowEnd != expEnd || !rstN && rowEnd) begin
      fails++;
      $display("FAIL R1/R3/R6/R7/R9/R10 line: font=%0d blank=%0b end=%0b expected font=%0d blank=%0b end=%0b",
               fontLine, blankLine, rowEnd, expFont, expBlank, expEnd);
    end
    sawEnd = rowEnd;
    if (rstN) begin
      if (rs) buildRow(heightCode, dblHeight, rowSpace);
      else if (ls && q.size() > 0) void'(q.pop_front());
    end
    @(posedge clk);
    #1;
  endtask

  task automatic runRow(input logic [6:0] code, input logic dbl, input logic [4:0] sp,
                        input int expTotal, input string tag);
    int cnt = 0;
    heightCode = code; dblHeight = dbl; rowSpace = sp;
    step(1'b1, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic ls = (i % 4) != 3;
      step(1'b0, ls);
      if (ls) cnt++;
      if (sawEnd) break;
    end
    checks++;
    if (cnt != expTotal) begin
      fails++;
      $display("FAIL %s total lines: got %0d expected %0d", tag, cnt, expTotal);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run expected completion");
    finishRun();
  end

  initial begin
    // R10: reset state and idle strobes
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    rstN = 1'b1;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);

    runRow(7'h00, 1'b0, 5'd0,  18, "R4 default code");
    runRow(7'h0D, 1'b0, 5'd0,  31, "R2 bits 0,2,3");
    runRow(7'h19, 1'b0, 5'd0,  35, "R2 bits 0,3,4");
    runRow(7'h1F, 1'b0, 5'd0,  35, "R2 cap at 17");
    runRow(7'h4A, 1'b0, 5'd0,  46, "R4 repeat once");
    runRow(7'h7F, 1'b0, 5'd0,  71, "R4 repeat twice max");
    runRow(7'h25, 1'b0, 5'd3,  26, "R4 bit6 clear ignores bit5, R6");
    runRow(7'h03, 1'b1, 5'd0,  42, "R5 double height");
    runRow(7'h7F, 1'b1, 5'd31, 173, "R5 R6 largest row");
    runRow(7'h11, 1'b0, 5'd1,  36, "R3 R6 single space");
    step(1'b0, 1'b1);                 // R10: strobe after end ignored
    step(1'b0, 1'b1);

    // R8: settings changed mid-row have no effect
    heightCode = 7'h00; dblHeight = 1'b0; rowSpace = 5'd0;
    step(1'b1, 1'b0);
    step(1'b0, 1'b1); step(1'b0, 1'b1); step(1'b0, 1'b1);
    heightCode = 7'h7F; dblHeight = 1'b1; rowSpace = 5'd31;
    begin
      int cnt = 3;
      for (int i = 0; i < 100; i++) begin
        step(1'b0, 1'b1); cnt++;
        if (sawEnd) break;
      end
      checks++;
      if (cnt != 18) begin
        fails++;
        $display("FAIL R8 mid-row change: got %0d expected %0d", cnt, 18);
      end
    end

    // R9: rowStart with lineStb mid-row, and on the would-be last line
    heightCode = 7'h05; dblHeight = 1'b0; rowSpace = 5'd2;
    step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);                 // q has one line left: restart instead of end
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);

    finishRun();
  end

endmodule